// File: doc/BRIEF.md
# DMA Source Gather Address Generator

This block produces the source address stream for one DMA channel. Software programs a gather register that holds a beat count and a stride. A start pulse then loads the first address. On each accepted beat the address moves on by one transfer width. After every programmed number of contiguous beats, the address makes an additional jump of a programmed number of widths. That jump goes the same way as the normal step, up or down. A fixed-address mode keeps the address still and ignores the gather settings.

The transfer width code and the direction control are sampled live on each beat. The gather register is sampled live too. Gather support is a build-time option. Without it the register does not exist, reads return zero, and addresses advance linearly.

Top module: `dma_gather_addr_gen`

## Requirements
- R1: While reset is low, `addr_out` is 0 and `cfg_rdata` is 0. The stored gather count and stride are both 0.
- R2: A write stores the stride from `cfg_wdata[19:0]` and the count from `cfg_wdata[B:20]`, where B = log2(MAX_BLK+1)+19. `cfg_rdata` returns those fields in the same positions, and every bit above B reads 0. Bits 63:32 are therefore always 0.
- R3: A `start` pulse loads `start_addr` into `addr_out` on the next cycle and clears the beat position. When `start` and `beat_ok` are high together, `start` wins.
- R4: When the gather count is 0, each accepted beat in increment mode adds 1<<c bytes, where c is `width_code` limited to at most 5. Codes 6 and 7 act as 5.
- R5: When the gather count N is nonzero, every N-th accepted beat after start is a boundary beat. A boundary beat moves the address by width*(1+stride) instead of by width. If the beat position is at or past N, the next beat is a boundary beat.
- R6: When `dir_mode` is 01, every step magnitude from R4 and R5 is subtracted instead of added. Addresses wrap modulo 2^ADDR_W.
- R7: When `dir_mode[1]` is 1, accepted beats leave both the address and the beat position unchanged, whatever the gather fields hold.
- R8: Without `start` or `beat_ok`, `addr_out` holds its value.
- R9: With GATHER_EN=0, writes are ignored, `cfg_rdata` is 0 and addresses step linearly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load start address, clear beat position |
| start_addr | input | ADDR_W | First source address |
| width_code | input | 3 | Transfer width code (byte step 1<<code, max 5) |
| dir_mode | input | 2 | 00 increment, 01 decrement, 1x fixed |
| beat_ok | input | 1 | Beat accepted this cycle |
| addr_out | output | ADDR_W | Address of the current beat |
| cfg_we | input | 1 | Gather register write strobe |
| cfg_wdata | input | CNT_W+20 | Gather register write data (implemented bits) |
| cfg_rdata | output | 64 | Gather register read-back |

## Verification
The hardest case is a change to the gather count while a run is in progress, so that the beat position is already at or past the new count. It is hard to reach because it needs a register write in the middle of a run. Random stimulus writes the register at random points without restarting and mixes random directions and widths into every beat. This drives the "at or past" rule of R5 many times. Directed runs pin the exact boundary addresses for both directions, and a second instance built without gather support runs the same stimulus.

// File: rtl/gather_pkg.sv
package gather_pkg;
    localparam int MAX_CODE = 5;

    // Limit a width code to the widest supported transfer.
    function automatic logic [2:0] clamp_code(input logic [2:0] code);
        return (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
    endfunction
endpackage

// File: rtl/gather_reg.sv
module gather_reg #(
    parameter int CNT_W     = 10,
    parameter bit GATHER_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W+19:0] wdata,
    output logic [63:0]      rdata,
    output logic [CNT_W-1:0] count,
    output logic [19:0]      stride
);
    localparam int REG_W = CNT_W + 20;

    logic [REG_W-1:0] field_d, field_q;

    always_comb begin
        field_d = field_q;
        if (we && GATHER_EN) begin
            field_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) field_q <= '0;
        else        field_q <= field_d;
    end

    generate
        if (GATHER_EN) begin : g_present
            assign stride = field_q[19:0];
            assign count  = field_q[REG_W-1:20];
            assign rdata  = {{(64-REG_W){1'b0}}, field_q};
        end else begin : g_absent
            logic unused_field;
            assign unused_field = ^field_q;
            assign stride = '0;
            assign count  = '0;
            assign rdata  = '0;
        end
    endgenerate
endmodule

// File: rtl/gather_step.sv
module gather_step #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic [2:0]        width_code,
    input  logic [19:0]       stride,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  pos,
    output logic [ADDR_W-1:0] delta,
    output logic [CNT_W-1:0]  pos_nxt
);
    import gather_pkg::*;

    logic [2:0]        code;
    logic [ADDR_W-1:0] width_bytes;
    logic [ADDR_W-1:0] jump;
    logic              boundary;

    always_comb begin
        code        = clamp_code(width_code);
        width_bytes = ADDR_W'(1) << code;
        jump        = ADDR_W'(stride) << code;
        boundary    = (count != '0) && (({1'b0, pos} + 1'b1) >= {1'b0, count});
        delta       = boundary ? (width_bytes + jump) : width_bytes;
        pos_nxt     = (boundary || count == '0) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/dma_gather_addr_gen.sv
module dma_gather_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BLK   = 1023,
    parameter bit GATHER_EN = 1'b1,
    localparam int CNT_W    = $clog2(MAX_BLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        width_code,
    input  logic [1:0]        dir_mode,
    input  logic              beat_ok,
    output logic [ADDR_W-1:0] addr_out,
    input  logic              cfg_we,
    input  logic [CNT_W+19:0] cfg_wdata,
    output logic [63:0]       cfg_rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  pos;
    } state_t;

    state_t            st_d, st_q;
    logic [CNT_W-1:0]  count;
    logic [19:0]       stride;
    logic [ADDR_W-1:0] delta;
    logic [CNT_W-1:0]  pos_nxt;
    logic              fixed_mode, down_mode;

    gather_reg #(.CNT_W(CNT_W), .GATHER_EN(GATHER_EN)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .count(count), .stride(stride)
    );

    gather_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
        .width_code(width_code), .stride(stride), .count(count),
        .pos(st_q.pos), .delta(delta), .pos_nxt(pos_nxt)
    );

    assign fixed_mode = dir_mode[1];
    assign down_mode  = dir_mode[0];

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.addr = start_addr;
            st_d.pos  = '0;
        end else if (beat_ok && !fixed_mode) begin
            st_d.addr = down_mode ? (st_q.addr - delta) : (st_q.addr + delta);
            st_d.pos  = pos_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_out = st_q.addr;
endmodule

// File: rtl/gather_checker.sv
module gather_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [2:0]        width_code,
    input logic [1:0]        dir_mode,
    input logic              beat_ok,
    input logic [ADDR_W-1:0] addr_out,
    input logic [63:0]       cfg_rdata
);
    import gather_pkg::*;

    logic lin_beat;
    assign lin_beat = !start && beat_ok && !dir_mode[1] && (cfg_rdata[CNT_W+19:20] == '0);

    assert_reset_R1: assert property (@(posedge clk) !rst_n |-> (addr_out == '0 && cfg_rdata == '0));

    assert_rd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[63:CNT_W+20] == '0);

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr_out == $past(start_addr));

    assert_linear_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_beat && !dir_mode[0]) |=>
        addr_out == $past(addr_out) + (ADDR_W'(1) << clamp_code($past(width_code))));

    assert_linear_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_beat && dir_mode[0]) |=>
        addr_out == $past(addr_out) - (ADDR_W'(1) << clamp_code($past(width_code))));

    assert_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && dir_mode[1]) |=> $stable(addr_out));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !beat_ok) |=> $stable(addr_out));
endmodule

bind dma_gather_addr_gen gather_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .width_code(width_code), .dir_mode(dir_mode), .beat_ok(beat_ok),
    .addr_out(addr_out), .cfg_rdata(cfg_rdata)
);

// File: tb/test_dma_gather_addr_gen.sv
module test_dma_gather_addr_gen;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [2:0]        width_code = '0;
    logic [1:0]        dir_mode = '0;
    logic              beat_ok = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CNT_W+19:0] cfg_wdata = '0;
    logic [ADDR_W-1:0] addr_out, lin_addr;
    logic [63:0]       cfg_rdata, lin_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    // reference state
    logic [ADDR_W-1:0] exp_addr = '0, exp_lin = '0;
    int exp_pos = 0;
    int m_cnt = 0, m_str = 0;

    always #2 clk = ~clk;

    dma_gather_addr_gen #(.ADDR_W(ADDR_W), .MAX_BLK(1023)) i_dma_gather_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .width_code(width_code), .dir_mode(dir_mode), .beat_ok(beat_ok),
        .addr_out(addr_out), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    dma_gather_addr_gen #(.ADDR_W(ADDR_W), .MAX_BLK(1023), .GATHER_EN(1'b0)) i_lin (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .width_code(width_code), .dir_mode(dir_mode), .beat_ok(beat_ok),
        .addr_out(lin_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(lin_rdata)
    );

    function automatic int eff_code(input logic [2:0] c);
        return (c > 3'd5) ? 5 : int'(c);
    endfunction

    function automatic logic [ADDR_W-1:0] step_size(input int pos, input int cnt,
                                                    input int str, input logic [2:0] c);
        logic [ADDR_W-1:0] w;
        w = ADDR_W'(1) << eff_code(c);
        if (cnt != 0 && pos + 1 >= cnt) return w + (ADDR_W'(str) << eff_code(c));
        return w;
    endfunction

    function automatic int next_pos(input int pos, input int cnt);
        if (cnt == 0 || pos + 1 >= cnt) return 0;
        return pos + 1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: update the reference at the edge, compare at the falling edge
    task automatic tick();
        logic [ADDR_W-1:0] d;
        @(posedge clk);
        if (!rst_n) begin
            exp_addr = '0; exp_lin = '0; exp_pos = 0; m_cnt = 0; m_str = 0;
        end else begin
            if (start) begin
                exp_addr = start_addr; exp_lin = start_addr; exp_pos = 0;
            end else if (beat_ok && !dir_mode[1]) begin
                d = step_size(exp_pos, m_cnt, m_str, width_code);
                exp_addr = dir_mode[0] ? exp_addr - d : exp_addr + d;
                d = step_size(0, 0, 0, width_code);
                exp_lin = dir_mode[0] ? exp_lin - d : exp_lin + d;
                exp_pos = next_pos(exp_pos, m_cnt);
            end
            if (cfg_we) begin
                m_str = int'(cfg_wdata[19:0]);
                m_cnt = int'(cfg_wdata[CNT_W+19:20]);
            end
        end
        @(negedge clk);
        check({cur_tag, " addr"}, 64'(addr_out), 64'(exp_addr));
        check("R9 linear addr", 64'(lin_addr), 64'(exp_lin));
        check("R2/R9 rdata lin", lin_rdata, 64'h0);
        check("R2 rdata", cfg_rdata, {34'h0, 10'(m_cnt), 20'(m_str)});
    endtask

    task automatic set_in(input bit s, input logic [ADDR_W-1:0] sa, input logic [2:0] c,
                          input logic [1:0] dm, input bit b);
        start = s; start_addr = sa; width_code = c; dir_mode = dm; beat_ok = b;
    endtask

    task automatic write_reg(input int cnt, input int str);
        cfg_we = 1'b1; cfg_wdata = {10'(cnt), 20'(str)};
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1 reset values
        cur_tag = "R1";
        repeat (3) tick();
        check("R1 reset addr", 64'(addr_out), 64'h0);
        check("R1 reset rdata", cfg_rdata, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 packing and read mask
        cur_tag = "R2";
        cfg_we = 1'b1; cfg_wdata = '1;
        tick(); cfg_we = 1'b0;
        check("R2 all-ones read mask", cfg_rdata, 64'h0000_0000_3FFF_FFFF);
        write_reg(2, 3);
        check("R2 field packing", cfg_rdata, 64'h0000_0000_0020_0003);

        // R5 increment gather: 0x100,0x104,0x114,0x118,0x128
        cur_tag = "R5";
        set_in(1, 32'h100, 3'd2, 2'b00, 0); tick();
        check("R3 start load", 64'(addr_out), 64'h100);
        set_in(0, 0, 3'd2, 2'b00, 1);
        tick(); check("R5 beat1", 64'(addr_out), 64'h104);
        tick(); check("R5 boundary jump", 64'(addr_out), 64'h114);
        tick(); tick(); check("R5 second boundary", 64'(addr_out), 64'h128);

        // R6 decrement gather: 0x1000 -> 0xFFF,0xFFB,0xFFA,0xFF6
        cur_tag = "R6";
        set_in(1, 32'h1000, 3'd0, 2'b01, 0); tick();
        set_in(0, 0, 3'd0, 2'b01, 1);
        repeat (4) tick();
        check("R6 decrement boundary", 64'(addr_out), 64'hFF6);

        // R7 fixed mode with gather fields set
        cur_tag = "R7";
        set_in(0, 0, 3'd3, 2'b10, 1); repeat (5) tick();
        check("R7 fixed holds", 64'(addr_out), 64'hFF6);

        // R8 no accept holds
        cur_tag = "R8";
        set_in(0, 0, 3'd3, 2'b00, 0); repeat (3) tick();
        check("R8 idle holds", 64'(addr_out), 64'hFF6);

        // R3 start beats a simultaneous beat
        cur_tag = "R3";
        set_in(1, 32'h2000, 3'd1, 2'b00, 1); tick();
        check("R3 start wins over beat", 64'(addr_out), 64'h2000);

        // R4 count zero, code 7 acts as 5
        cur_tag = "R4";
        write_reg(0, 5);
        set_in(1, 32'h0, 3'd7, 2'b00, 0); tick();
        set_in(0, 0, 3'd7, 2'b00, 1); tick();
        check("R4 code clamp", 64'(addr_out), 64'h20);
        set_in(0, 0, 3'd4, 2'b00, 1); tick(); tick();
        check("R4 linear step", 64'(addr_out), 64'h40);

        // random mix, register rewritten mid-run (R4 R5 R6 R7 R8 R3)
        cur_tag = "R5 random";
        for (int i = 0; i < 4000; i++) begin
            set_in(($urandom_range(99) < 3), $urandom, 3'($urandom_range(7)),
                   2'($urandom_range(3)), ($urandom_range(99) < 70));
            cfg_we = ($urandom_range(99) < 5);
            cfg_wdata = {10'($urandom_range(99) < 80 ? $urandom_range(5) : $urandom_range(1023)),
                         20'($urandom_range(99) < 70 ? $urandom_range(15) : $urandom)};
            tick();
        end
        cfg_we = 1'b0;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule